// File: doc/BRIEF.md
# Scratchpad Tag Register Bank

This block holds the tag words of up to eight scratchpad memory regions and serves the indexed tag load and tag store operations that a processor issues. Every region owns two 32-bit tag words. Word 0 carries the region's physical page base and an enable flag, and software may rewrite it. Word 1 reports the region's size, which is fixed when the block is built. The size of each region is a parameter: a power of two of at least 4 KiB. A slot with no region behind it reports a size of zero.

Tag operations reach this bank only while the scratchpad-select bit of the error-control register is set. While that bit is clear, every tag operation passes unchanged to a separate cache-tag port, and the scratchpad tags stay as they are. Operations are accepted on any cycle. A registered controller steps through four named states. IDLE means no operation is in flight. TAG_LOAD returns a tag word on the read port. TAG_STORE commits a tag write. CACHE_FWD presents the operation on the cache-tag port. Every state can move to every other state on the next edge, chosen by the operation offered in the current cycle: none to IDLE, a select-clear operation to CACHE_FWD, a select-set store to TAG_STORE, and a select-set load to TAG_LOAD.

A second, purely combinational path compares an incoming physical page number against every enabled region. It raises a hit and names the region.

Top module: `spram_tag_bank`

## Requirements
- R1: After reset every region is disabled with a page base of zero. `rd_valid`, `cache_req_valid` and `addr_hit` are low, and a load of word 0 of any slot returns zero.
- R2: A load accepted with `sel_spram` high drives `rd_valid` high for exactly the following cycle. In that cycle word 0 of a populated slot reads as page base in bits 31:12, enable in bit 7, and zero in every other bit.
- R3: Word 1 of populated slot i reads as 2^SIZE_LOG2[i]. Both words of a slot at or above NUM_REGIONS read as zero.
- R4: A store accepted with `sel_spram` high to word 0 of a populated slot takes bits 31:12 as the page base and bit 7 as the enable. The other low bits of the store data are dropped.
- R5: A store to word 1, or to any word of an unpopulated slot, changes no tag.
- R6: The tag index selects the slot with bits 6:4 and the word with bit 3 (0 = base/enable, 1 = size). Bits 2:0 have no effect on which tag is reached.
- R7: An operation accepted with `sel_spram` low appears on the cache-tag port in the following cycle, with its store flag, index and data. It raises no `rd_valid` and leaves every scratchpad tag unchanged. An operation accepted with `sel_spram` high never reaches the cache-tag port.
- R8: `addr_hit` is high exactly when some enabled region i has `pa_page` equal to its base after both are masked to that region's size. The low page bits of a misaligned base are ignored. Disabled regions never hit.
- R9: When several regions match, `addr_region` names the lowest-numbered one.
- R10: Operations offered on consecutive cycles are each served, one cycle after their own acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_spram | input | 1 | Scratchpad-select bit (bit 28 of the error-control register) |
| op_valid | input | 1 | A tag operation is offered this cycle |
| op_store | input | 1 | 1 = tag store, 0 = tag load |
| op_index | input | 7 | Byte index into tag space |
| op_wdata | input | 32 | Tag-low register contents for a store |
| rd_valid | output | 1 | Load result present |
| rd_data | output | 32 | Tag word returned by a load |
| cache_req_valid | output | 1 | Operation forwarded to cache tags |
| cache_req_store | output | 1 | Store flag of forwarded operation |
| cache_req_index | output | 7 | Index of forwarded operation |
| cache_req_wdata | output | 32 | Data of forwarded operation |
| pa_page | input | 20 | Physical address bits 31:12 to decode |
| addr_hit | output | 1 | Some enabled region contains `pa_page` |
| addr_region | output | 3 | Winning region number |

## Verification
The bench builds the bank with three populated regions of 4 KiB, 16 KiB and 8 KiB, so five of the eight slots stay empty. Every slot, both tag words and two low-bit patterns can then be swept for loads and stores, including the slots that must read as zero and refuse writes. The different sizes let one address sweep of a few dozen pages cover overlapping regions, a misaligned base, priority between overlaps, and a disabled region. Each case is compared with values that the bench computes from its own model of the tags.

// File: rtl/spram_tag_pkg.sv
package spram_tag_pkg;

    localparam int unsigned TAG_W      = 32;
    localparam int unsigned PAGE_LSB   = 12;
    localparam int unsigned PAGE_W     = TAG_W - PAGE_LSB;
    localparam int unsigned ENABLE_BIT = 7;
    localparam int unsigned WORD_BIT   = 3;
    localparam int unsigned SLOT_LSB   = 4;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TAG_LOAD  = 2'd1,
        ST_TAG_STORE = 2'd2,
        ST_CACHE_FWD = 2'd3
    } tag_state_e;

    // Size of a region in pages (4 KiB units) from its log2 byte size.
    function automatic logic [PAGE_W-1:0] size_pages(input int unsigned lg);
        return PAGE_W'(1) << (lg - PAGE_LSB);
    endfunction

    // Page mask that keeps only the bits above the region size.
    function automatic logic [PAGE_W-1:0] page_mask(input int unsigned lg);
        return ~(size_pages(lg) - PAGE_W'(1));
    endfunction

    // Word 0 image: page base high, enable flag, everything else zero.
    function automatic logic [TAG_W-1:0] pack_word0(input logic [PAGE_W-1:0] page,
                                                    input logic en);
        logic [TAG_W-1:0] w;
        w = '0;
        w[TAG_W-1:PAGE_LSB] = page;
        w[ENABLE_BIT] = en;
        return w;
    endfunction

endpackage

// File: rtl/spram_tag_ctrl.sv
module spram_tag_ctrl
    import spram_tag_pkg::*;
#(
    parameter int unsigned IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_spram,
    input  logic             op_valid,
    input  logic             op_store,
    input  logic [IDX_W-1:0] op_index,
    input  logic [TAG_W-1:0] op_wdata,
    output logic [IDX_W-1:0] lat_index,
    output logic [TAG_W-1:0] lat_wdata,
    output logic             rd_strobe,
    output logic             wr_strobe,
    output logic             fwd_valid,
    output logic             fwd_store
);

    tag_state_e state_q, state_d;
    logic       lat_store;

    // Next state: chosen by the operation offered this cycle.
    always_comb begin
        state_d = ST_IDLE;
        if (op_valid) begin
            if (!sel_spram) begin
                state_d = ST_CACHE_FWD;
            end else if (op_store) begin
                state_d = ST_TAG_STORE;
            end else begin
                state_d = ST_TAG_LOAD;
            end
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operation fields captured at acceptance.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_index <= '0;
            lat_wdata <= '0;
            lat_store <= 1'b0;
        end else if (op_valid) begin
            lat_index <= op_index;
            lat_wdata <= op_wdata;
            lat_store <= op_store;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        rd_strobe = 1'b0;
        wr_strobe = 1'b0;
        fwd_valid = 1'b0;
        fwd_store = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_TAG_LOAD: begin
                rd_strobe = 1'b1;
            end
            ST_TAG_STORE: begin
                wr_strobe = 1'b1;
            end
            ST_CACHE_FWD: begin
                fwd_valid = 1'b1;
                fwd_store = lat_store;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/spram_tag_regs.sv
module spram_tag_regs
    import spram_tag_pkg::*;
#(
    parameter int unsigned SLOTS       = 8,
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned SIZE_LOG2 [SLOTS] = '{12, 13, 14, 16, 12, 12, 12, 12},
    localparam int unsigned RGN_W      = $clog2(SLOTS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_strobe,
    input  logic [RGN_W-1:0]             tag_slot,
    input  logic                         tag_word,
    input  logic [PAGE_W-1:0]            wr_page,
    input  logic                         wr_enable,
    output logic [TAG_W-1:0]             rd_word_data,
    output logic [SLOTS-1:0]             slot_en,
    output logic [SLOTS-1:0][PAGE_W-1:0] slot_base
);

    logic [SLOTS-1:0][PAGE_W-1:0] slot_size;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < NUM_REGIONS) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    slot_base[g] <= '0;
                    slot_en[g]   <= 1'b0;
                end else if (wr_strobe && !tag_word && tag_slot == RGN_W'(g)) begin
                    slot_base[g] <= wr_page;
                    slot_en[g]   <= wr_enable;
                end
            end
            assign slot_size[g] = size_pages(SIZE_LOG2[g]);
        end else begin : g_empty
            assign slot_base[g] = '0;
            assign slot_en[g]   = 1'b0;
            assign slot_size[g] = '0;
        end
    end

    always_comb begin
        if (tag_word) begin
            rd_word_data = {slot_size[tag_slot], {PAGE_LSB{1'b0}}};
        end else begin
            rd_word_data = pack_word0(slot_base[tag_slot], slot_en[tag_slot]);
        end
    end

endmodule

// File: rtl/spram_addr_match.sv
module spram_addr_match
    import spram_tag_pkg::*;
#(
    parameter int unsigned SLOTS       = 8,
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned SIZE_LOG2 [SLOTS] = '{12, 13, 14, 16, 12, 12, 12, 12},
    localparam int unsigned RGN_W      = $clog2(SLOTS)
) (
    input  logic [PAGE_W-1:0]            pa_page,
    input  logic [SLOTS-1:0]             slot_en,
    input  logic [SLOTS-1:0][PAGE_W-1:0] slot_base,
    output logic                         hit,
    output logic [RGN_W-1:0]             hit_region
);

    logic [SLOTS-1:0] match;

    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        if (g < NUM_REGIONS) begin : g_live
            localparam logic [PAGE_W-1:0] MASK = page_mask(SIZE_LOG2[g]);
            assign match[g] = slot_en[g] && ((pa_page & MASK) == (slot_base[g] & MASK));
        end else begin : g_empty
            assign match[g] = 1'b0;
        end
    end

    // Lowest-numbered matching region wins.
    always_comb begin
        hit        = 1'b0;
        hit_region = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit        = 1'b1;
                hit_region = RGN_W'(i);
            end
        end
    end

endmodule

// File: rtl/spram_tag_bank.sv
module spram_tag_bank
    import spram_tag_pkg::*;
#(
    parameter int unsigned SLOTS       = 8,
    parameter int unsigned NUM_REGIONS = 4,
    parameter int unsigned SIZE_LOG2 [SLOTS] = '{12, 13, 14, 16, 12, 12, 12, 12},
    localparam int unsigned RGN_W      = $clog2(SLOTS),
    localparam int unsigned IDX_W      = RGN_W + SLOT_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_spram,
    input  logic             op_valid,
    input  logic             op_store,
    input  logic [IDX_W-1:0] op_index,
    input  logic [TAG_W-1:0] op_wdata,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_data,
    output logic             cache_req_valid,
    output logic             cache_req_store,
    output logic [IDX_W-1:0] cache_req_index,
    output logic [TAG_W-1:0] cache_req_wdata,
    input  logic [PAGE_W-1:0] pa_page,
    output logic             addr_hit,
    output logic [RGN_W-1:0] addr_region
);

    logic [IDX_W-1:0]             lat_index;
    logic [TAG_W-1:0]             lat_wdata;
    logic                         rd_strobe;
    logic                         wr_strobe;
    logic                         fwd_valid;
    logic                         fwd_store;
    logic [TAG_W-1:0]             bank_word;
    logic [SLOTS-1:0]             slot_en;
    logic [SLOTS-1:0][PAGE_W-1:0] slot_base;

    spram_tag_ctrl #(
        .IDX_W (IDX_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_spram (sel_spram),
        .op_valid  (op_valid),
        .op_store  (op_store),
        .op_index  (op_index),
        .op_wdata  (op_wdata),
        .lat_index (lat_index),
        .lat_wdata (lat_wdata),
        .rd_strobe (rd_strobe),
        .wr_strobe (wr_strobe),
        .fwd_valid (fwd_valid),
        .fwd_store (fwd_store)
    );

    spram_tag_regs #(
        .SLOTS       (SLOTS),
        .NUM_REGIONS (NUM_REGIONS),
        .SIZE_LOG2   (SIZE_LOG2)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_strobe    (wr_strobe),
        .tag_slot     (lat_index[IDX_W-1:SLOT_LSB]),
        .tag_word     (lat_index[WORD_BIT]),
        .wr_page      (lat_wdata[TAG_W-1:PAGE_LSB]),
        .wr_enable    (lat_wdata[ENABLE_BIT]),
        .rd_word_data (bank_word),
        .slot_en      (slot_en),
        .slot_base    (slot_base)
    );

    spram_addr_match #(
        .SLOTS       (SLOTS),
        .NUM_REGIONS (NUM_REGIONS),
        .SIZE_LOG2   (SIZE_LOG2)
    ) u_match (
        .pa_page    (pa_page),
        .slot_en    (slot_en),
        .slot_base  (slot_base),
        .hit        (addr_hit),
        .hit_region (addr_region)
    );

    assign rd_valid        = rd_strobe;
    assign rd_data         = rd_strobe ? bank_word : '0;
    assign cache_req_valid = fwd_valid;
    assign cache_req_store = fwd_store;
    assign cache_req_index = fwd_valid ? lat_index : '0;
    assign cache_req_wdata = fwd_valid ? lat_wdata : '0;

endmodule

// File: rtl/spram_tag_bank_chk.sv
module spram_tag_bank_chk #(
    parameter int unsigned SLOTS = 8,
    parameter int unsigned IDX_W = 7,
    localparam int unsigned RGN_W = $clog2(SLOTS)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sel_spram,
    input logic                    op_valid,
    input logic                    op_store,
    input logic [IDX_W-1:0]        op_index,
    input logic [31:0]             op_wdata,
    input logic                    rd_valid,
    input logic                    cache_req_valid,
    input logic [IDX_W-1:0]        cache_req_index,
    input logic [31:0]             cache_req_wdata,
    input logic                    addr_hit,
    input logic [RGN_W-1:0]        addr_region,
    input logic [SLOTS-1:0]        slot_en,
    input logic [SLOTS-1:0][19:0]  slot_base
);

    AST_NO_DUAL_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && cache_req_valid));  // R7

    AST_LOAD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && sel_spram && !op_store |=> rd_valid);  // R2

    AST_FWD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !sel_spram |=> cache_req_valid && cache_req_index == $past(op_index)
                                   && cache_req_wdata == $past(op_wdata));  // R7

    AST_SEL_NO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && sel_spram |=> !cache_req_valid);  // R7

    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        addr_hit |-> slot_en[addr_region]);  // R8

    AST_SIZE_WORD_RO: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && sel_spram && op_store && op_index[3]
        |=> ##1 ($stable(slot_en) && $stable(slot_base)));  // R5

endmodule

bind spram_tag_bank spram_tag_bank_chk #(
    .SLOTS (SLOTS),
    .IDX_W (IDX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sel_spram       (sel_spram),
    .op_valid        (op_valid),
    .op_store        (op_store),
    .op_index        (op_index),
    .op_wdata        (op_wdata),
    .rd_valid        (rd_valid),
    .cache_req_valid (cache_req_valid),
    .cache_req_index (cache_req_index),
    .cache_req_wdata (cache_req_wdata),
    .addr_hit        (addr_hit),
    .addr_region     (addr_region),
    .slot_en         (slot_en),
    .slot_base       (slot_base)
);

// File: tb/spram_tag_bank_tb.sv
module spram_tag_bank_tb;

    localparam int CLK_PERIOD = 10;
    localparam int unsigned SLOTS = 8;
    localparam int unsigned NREG = 3;
    localparam int unsigned SZ [SLOTS] = '{12, 14, 13, 12, 12, 12, 12, 12};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_spram = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_store = 1'b0;
    logic [6:0]  op_index = '0;
    logic [31:0] op_wdata = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        cache_req_valid;
    logic        cache_req_store;
    logic [6:0]  cache_req_index;
    logic [31:0] cache_req_wdata;
    logic [19:0] pa_page = '0;
    logic        addr_hit;
    logic [2:0]  addr_region;

    int checks = 0;
    int fails = 0;

    logic [19:0] m_base [SLOTS];
    logic        m_en   [SLOTS];

    always #(CLK_PERIOD / 2) clk = ~clk;

    spram_tag_bank #(
        .SLOTS       (SLOTS),
        .NUM_REGIONS (NREG),
        .SIZE_LOG2   (SZ)
    ) u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .sel_spram       (sel_spram),
        .op_valid        (op_valid),
        .op_store        (op_store),
        .op_index        (op_index),
        .op_wdata        (op_wdata),
        .rd_valid        (rd_valid),
        .rd_data         (rd_data),
        .cache_req_valid (cache_req_valid),
        .cache_req_store (cache_req_store),
        .cache_req_index (cache_req_index),
        .cache_req_wdata (cache_req_wdata),
        .pa_page         (pa_page),
        .addr_hit        (addr_hit),
        .addr_region     (addr_region)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic [6:0] idx);
        int unsigned s;
        s = int'(idx[6:4]);
        if (s >= NREG) return 32'h0;
        if (idx[3]) return 32'(1) << SZ[s];
        return {m_base[s], 4'h0, m_en[s], 7'h0};
    endfunction

    // Drive one operation, return at the falling edge after acceptance.
    task automatic issue(input logic sel, input logic st, input logic [6:0] idx,
                         input logic [31:0] wd);
        @(negedge clk);
        sel_spram = sel;
        op_valid  = 1'b1;
        op_store  = st;
        op_index  = idx;
        op_wdata  = wd;
        @(negedge clk);
        op_valid  = 1'b0;
    endtask

    task automatic model_store(input logic [6:0] idx, input logic [31:0] wd);
        int unsigned s;
        s = int'(idx[6:4]);
        if (s < NREG && !idx[3]) begin
            m_base[s] = wd[31:12];
            m_en[s]   = wd[7];
        end
    endtask

    task automatic load_sweep(input string req);
        for (int s = 0; s < int'(SLOTS); s++) begin
            for (int w = 0; w < 2; w++) begin
                for (int lo = 0; lo < 8; lo += 5) begin
                    logic [6:0] idx;
                    idx = {3'(s), 1'(w), 3'(lo)};
                    issue(1'b1, 1'b0, idx, 32'h0);
                    check({req, " R2 rd_valid"}, 32'(rd_valid), 32'h1);
                    check({req, " R7 no fwd"}, 32'(cache_req_valid), 32'h0);
                    check({req, (w == 1) ? " R3 size" : " R6 word0"}, rd_data, exp_word(idx));
                end
            end
        end
    endtask

    task automatic hit_sweep(input string req);
        for (int p = 32'h1BFFE; p <= 32'h1C00A; p++) begin
            logic       eh;
            logic [2:0] er;
            eh = 1'b0;
            er = '0;
            for (int r = int'(NREG) - 1; r >= 0; r--) begin
                logic [19:0] mk;
                mk = ~((20'(1) << (SZ[r] - 12)) - 20'(1));
                if (m_en[r] && ((20'(p) ^ m_base[r]) & mk) == 20'h0) begin
                    eh = 1'b1;
                    er = 3'(r);
                end
            end
            @(negedge clk);
            pa_page = 20'(p);
            #1;
            check({req, " R8 hit"}, 32'(addr_hit), 32'(eh));
            if (eh) check({req, " R9 region"}, 32'(addr_region), 32'(er));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < int'(SLOTS); s++) begin
            m_base[s] = '0;
            m_en[s]   = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pa_page = 20'h00000;
        @(negedge clk);
        #1;
        // R1: quiet outputs and cleared tags after reset
        check("R1 rd_valid", 32'(rd_valid), 32'h0);
        check("R1 cache_req_valid", 32'(cache_req_valid), 32'h0);
        check("R1 addr_hit", 32'(addr_hit), 32'h0);
        issue(1'b1, 1'b0, 7'h00, 32'h0);
        check("R1 word0 zero", rd_data, 32'h0);

        load_sweep("reset");

        // R4 R5 R6: store sweep over all slots and both words
        for (int s = 0; s < int'(SLOTS); s++) begin
            for (int w = 0; w < 2; w++) begin
                logic [6:0]  idx;
                logic [31:0] wd;
                idx = {3'(s), 1'(w), 3'(s)};
                wd = 32'h1C000000 | (32'(s) << 14) | ((s % 2 == 1) ? 32'h0000_007F : 32'h0000_0FFF);
                issue(1'b1, 1'b1, idx, wd);
                check("R4 store no rd_valid", 32'(rd_valid), 32'h0);
                model_store(idx, wd);
            end
        end
        load_sweep("after store R4 R5");

        // R7: select clear goes to the cache-tag port
        issue(1'b0, 1'b1, 7'h10, 32'hDEAD_BEEF);
        check("R7 fwd valid", 32'(cache_req_valid), 32'h1);
        check("R7 fwd store", 32'(cache_req_store), 32'h1);
        check("R7 fwd index", 32'(cache_req_index), 32'h10);
        check("R7 fwd data", cache_req_wdata, 32'hDEAD_BEEF);
        check("R7 no rd_valid", 32'(rd_valid), 32'h0);
        issue(1'b0, 1'b0, 7'h0B, 32'h1234_5678);
        check("R7 fwd load flag", 32'(cache_req_store), 32'h0);
        check("R7 fwd load index", 32'(cache_req_index), 32'h0B);
        issue(1'b1, 1'b0, 7'h10, 32'h0);
        check("R7 tag unchanged", rd_data, exp_word(7'h10));

        // R8 R9: overlapping regions, misaligned base
        issue(1'b1, 1'b1, 7'h00, 32'h1C000080); model_store(7'h00, 32'h1C000080);
        issue(1'b1, 1'b1, 7'h10, 32'h1C005080); model_store(7'h10, 32'h1C005080);
        issue(1'b1, 1'b1, 7'h20, 32'h1C000080); model_store(7'h20, 32'h1C000080);
        hit_sweep("all enabled");
        issue(1'b1, 1'b1, 7'h00, 32'h1C000000); model_store(7'h00, 32'h1C000000);
        hit_sweep("r0 disabled");

        // R10: back-to-back operations
        @(negedge clk);
        sel_spram = 1'b1; op_valid = 1'b1; op_store = 1'b0; op_index = 7'h18; op_wdata = '0;
        @(negedge clk);
        check("R10 first load valid", 32'(rd_valid), 32'h1);
        check("R10 first load data", rd_data, exp_word(7'h18));
        op_store = 1'b1; op_index = 7'h20; op_wdata = 32'h1C0AB0FF;
        @(negedge clk);
        check("R10 store cycle quiet", 32'(rd_valid), 32'h0);
        model_store(7'h20, 32'h1C0AB0FF);
        op_store = 1'b0; op_index = 7'h21;
        @(negedge clk);
        op_valid = 1'b0;
        check("R10 load after store", rd_data, exp_word(7'h20));
        check("R10 load after store value", rd_data, 32'h1C0AB080);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule